// File: doc/BRIEF.md
# Crossing-Indexed Hit Store Writer

This block places incoming hit records into an external synchronous SRAM that is split into one fixed region per bunch crossing. Each crossing owns 64 consecutive words. The word address is the hit's 10-bit crossing stamp with a 6-bit slot number below it. A 32-entry count table, indexed by the low five stamp bits, keeps the next free slot for every crossing that is still open. Each accepted hit takes that slot, and the table entry is then incremented.

The block tracks a free-running crossing counter. A crossing closes once its age passes a programmable delay. The age of a stamp is the crossing counter minus the stamp, modulo 1024. Each time the counter advances, the block closes the crossing that has just fallen out of the window. It reports that crossing's final count on a strobe, writes an end-of-crossing word after the last hit, and clears the table entry for reuse. Late hits and hits for a full crossing are dropped and counted.

Top module: `delay_buffer_writer`

## Requirements
- R1: While reset is asserted and after it is released, `sram_we`, `sram_end`, `age_valid`, `rej_cnt` and `ovf_cnt` are 0, and `hit_ready` is 1 while `cur_ts` is unchanged.
- R2: An accepted hit produces one SRAM write in the cycle after acceptance. The address is `{hit_ts, slot}` (stamp in bits 15:6, slot in bits 5:0), `sram_wdata` carries the payload and `sram_end` is 0.
- R3: Successive accepted hits with the same stamp get slots 0, 1, 2, ... in order. Stamps with different low five bits count independently.
- R4: A hit whose age `(cur_ts - hit_ts) mod 1024` exceeds the effective delay is dropped and increments `rej_cnt`. An age equal to the delay is accepted, and the age is computed across the 1023-to-0 wrap.
- R5: The effective delay is `delay_cfg` limited to 1..30: a setting of 0 acts as 1 and 31 acts as 30. This applies to both rejection and closing.
- R6: A table entry never exceeds 64. A hit for a stamp that already holds 64 hits is dropped, is not written, and increments `ovf_cnt`.
- R7: In a cycle where `cur_ts` differs from its value in the previous cycle, the block closes stamp `t = (cur_ts - delay - 1) mod 1024`. In the next cycle `age_valid` pulses for one cycle with `age_ts = t` and `age_count` equal to the entry's count. An END word (`sram_end` = 1, data 0) is written at `{t, count[5:0]}`. The entry then reads as 0.
- R8: The END word is written when the count is 0. It is not written when the count is 64, and `age_valid` still pulses in that case.
- R9: In a cycle where `cur_ts` changes, `hit_ready` is 0 and an offered hit is neither written nor counted.
- R10: `rej_cnt` and `ovf_cnt` stop at their all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_ts | input | TS_W | Current crossing counter |
| delay_cfg | input | DLY_W | Requested window length in crossings |
| hit_valid | input | 1 | Hit offered |
| hit_ready | output | 1 | Hit taken this cycle when valid |
| hit_ts | input | TS_W | Crossing stamp of the offered hit |
| hit_data | input | PAYLOAD_W | Hit payload |
| sram_we | output | 1 | SRAM write strobe |
| sram_addr | output | TS_W+CNT_W | SRAM word address |
| sram_end | output | 1 | Word written is an end-of-crossing marker |
| sram_wdata | output | PAYLOAD_W | SRAM write data |
| age_valid | output | 1 | A crossing was closed |
| age_ts | output | TS_W | Stamp of the closed crossing |
| age_count | output | CNT_W+1 | Hits stored for the closed crossing |
| rej_cnt | output | CNTR_W | Saturating count of late hits |
| ovf_cnt | output | CNTR_W | Saturating count of hits beyond a full crossing |

## Verification
The bench keeps the default address geometry: 10-bit stamps, 64 slots and a 32-entry table. This lets it fill one crossing to exactly 64 hits and see the END word suppressed. It also lets it run the crossing counter through the 1023-to-0 wrap. The diagnostic counters are built only 4 bits wide, so 16 late hits are enough to reach saturation. The payload is narrowed to 16 bits.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

    // Action taken by the writer in one cycle; closing a crossing wins.
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_CLOSE,
        OP_STORE,
        OP_LATE,
        OP_FULL
    } dbw_op_e;

endpackage

// File: rtl/dbw_window.sv
module dbw_window #(
    parameter int TS_W    = 10,
    parameter int DLY_W   = 5,
    parameter int DLY_MIN = 1,
    parameter int DLY_MAX = 30
) (
    input  logic [TS_W-1:0]  cur_ts,
    input  logic [TS_W-1:0]  hit_ts,
    input  logic [DLY_W-1:0] delay_cfg,
    output logic [DLY_W-1:0] delay_eff,
    output logic             late,
    output logic [TS_W-1:0]  close_ts
);

    logic [TS_W-1:0] hit_age;
    logic [TS_W-1:0] dly_ext;

    always_comb begin
        if (delay_cfg < DLY_W'(DLY_MIN)) begin
            delay_eff = DLY_W'(DLY_MIN);
        end else if (delay_cfg > DLY_W'(DLY_MAX)) begin
            delay_eff = DLY_W'(DLY_MAX);
        end else begin
            delay_eff = delay_cfg;
        end
        dly_ext  = TS_W'(delay_eff);
        // modulo arithmetic: the subtraction wraps at the stamp width
        hit_age  = cur_ts - hit_ts;
        late     = hit_age > dly_ext;
        close_ts = cur_ts - dly_ext - TS_W'(1);
    end

endmodule

// File: rtl/dbw_ptr_cache.sv
module dbw_ptr_cache #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] hit_idx,
    output logic [CNT_W:0]   hit_cnt,
    input  logic [IDX_W-1:0] close_idx,
    output logic [CNT_W:0]   close_cnt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CNT_W:0]   wr_val
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W:0] CNT_FULL = {1'b1, {CNT_W{1'b0}}};

    logic [CNT_W:0] ent_d [ENTRIES];
    logic [CNT_W:0] ent_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = wr_val;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    assign hit_cnt   = ent_q[hit_idx];
    assign close_cnt = ent_q[close_idx];

    AST_ENTRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_val <= CNT_FULL); // R6

endmodule

// File: rtl/dbw_sat_counter.sv
module dbw_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);

    logic [W-1:0] value_d, value_q;

    always_comb begin
        value_d = value_q;
        if (inc && (value_q != {W{1'b1}})) begin
            value_d = value_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else begin
            value_q <= value_d;
        end
    end

    assign value = value_q;

    AST_CNT_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> value >= $past(value)); // R10

endmodule

// File: rtl/delay_buffer_writer.sv
module delay_buffer_writer
    import dbw_pkg::*;
#(
    parameter int TS_W      = 10,
    parameter int CNT_W     = 6,
    parameter int IDX_W     = 5,
    parameter int DLY_W     = 5,
    parameter int DLY_MIN   = 1,
    parameter int DLY_MAX   = 30,
    parameter int PAYLOAD_W = 32,
    parameter int CNTR_W    = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TS_W-1:0]       cur_ts,
    input  logic [DLY_W-1:0]      delay_cfg,
    input  logic                  hit_valid,
    output logic                  hit_ready,
    input  logic [TS_W-1:0]       hit_ts,
    input  logic [PAYLOAD_W-1:0]  hit_data,
    output logic                  sram_we,
    output logic [TS_W+CNT_W-1:0] sram_addr,
    output logic                  sram_end,
    output logic [PAYLOAD_W-1:0]  sram_wdata,
    output logic                  age_valid,
    output logic [TS_W-1:0]       age_ts,
    output logic [CNT_W:0]        age_count,
    output logic [CNTR_W-1:0]     rej_cnt,
    output logic [CNTR_W-1:0]     ovf_cnt
);

    localparam int ADDR_W = TS_W + CNT_W;
    localparam logic [CNT_W:0] CNT_FULL = {1'b1, {CNT_W{1'b0}}};

    typedef struct packed {
        logic                 we;
        logic                 is_end;
        logic [ADDR_W-1:0]    addr;
        logic [PAYLOAD_W-1:0] data;
        logic                 av;
        logic [TS_W-1:0]      ats;
        logic [CNT_W:0]       acnt;
        logic [TS_W-1:0]      prev_ts;
    } state_t;

    state_t s_d, s_q;

    logic [DLY_W-1:0] delay_eff;
    logic             late;
    logic [TS_W-1:0]  close_ts;
    logic [CNT_W:0]   hit_cnt;
    logic [CNT_W:0]   close_cnt;
    logic             c_wr_en;
    logic [IDX_W-1:0] c_wr_idx;
    logic [CNT_W:0]   c_wr_val;
    logic             rej_inc;
    logic             ovf_inc;
    logic             crossing_step;
    dbw_op_e          op;

    dbw_window #(
        .TS_W    (TS_W),
        .DLY_W   (DLY_W),
        .DLY_MIN (DLY_MIN),
        .DLY_MAX (DLY_MAX)
    ) u_window (
        .cur_ts    (cur_ts),
        .hit_ts    (hit_ts),
        .delay_cfg (delay_cfg),
        .delay_eff (delay_eff),
        .late      (late),
        .close_ts  (close_ts)
    );

    dbw_ptr_cache #(
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_idx   (hit_ts[IDX_W-1:0]),
        .hit_cnt   (hit_cnt),
        .close_idx (close_ts[IDX_W-1:0]),
        .close_cnt (close_cnt),
        .wr_en     (c_wr_en),
        .wr_idx    (c_wr_idx),
        .wr_val    (c_wr_val)
    );

    // Action select: a crossing step blocks the input for one cycle.
    always_comb begin
        crossing_step = (cur_ts != s_q.prev_ts);
        if (crossing_step) begin
            op = OP_CLOSE;
        end else if (!hit_valid) begin
            op = OP_IDLE;
        end else if (late) begin
            op = OP_LATE;
        end else if (hit_cnt == CNT_FULL) begin
            op = OP_FULL;
        end else begin
            op = OP_STORE;
        end
    end

    always_comb begin
        s_d         = s_q;
        s_d.we      = 1'b0;
        s_d.is_end  = 1'b0;
        s_d.av      = 1'b0;
        s_d.prev_ts = cur_ts;
        c_wr_en     = 1'b0;
        c_wr_idx    = hit_ts[IDX_W-1:0];
        c_wr_val    = hit_cnt + (CNT_W+1)'(1);
        rej_inc     = 1'b0;
        ovf_inc     = 1'b0;
        unique case (op)
            OP_CLOSE: begin
                s_d.av   = 1'b1;
                s_d.ats  = close_ts;
                s_d.acnt = close_cnt;
                if (close_cnt != CNT_FULL) begin
                    s_d.we     = 1'b1;
                    s_d.is_end = 1'b1;
                    s_d.addr   = {close_ts, close_cnt[CNT_W-1:0]};
                    s_d.data   = '0;
                end
                c_wr_en  = 1'b1;
                c_wr_idx = close_ts[IDX_W-1:0];
                c_wr_val = '0;
            end
            OP_STORE: begin
                s_d.we   = 1'b1;
                s_d.addr = {hit_ts, hit_cnt[CNT_W-1:0]};
                s_d.data = hit_data;
                c_wr_en  = 1'b1;
            end
            OP_LATE: rej_inc = 1'b1;
            OP_FULL: ovf_inc = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    dbw_sat_counter #(.W(CNTR_W)) u_rej (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (rej_inc),
        .value (rej_cnt)
    );

    dbw_sat_counter #(.W(CNTR_W)) u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (ovf_inc),
        .value (ovf_cnt)
    );

    assign hit_ready  = !crossing_step;
    assign sram_we    = s_q.we;
    assign sram_end   = s_q.is_end;
    assign sram_addr  = s_q.addr;
    assign sram_wdata = s_q.data;
    assign age_valid  = s_q.av;
    assign age_ts     = s_q.ats;
    assign age_count  = s_q.acnt;

    AST_END_WITH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && sram_end) |-> age_valid); // R7
    AST_NO_END_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (age_valid && age_count == CNT_FULL) |-> !sram_we); // R8
    AST_HIT_ADDR_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && !sram_end) |-> sram_addr[ADDR_W-1 -: TS_W] == $past(hit_ts)); // R2
    AST_STALL_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        age_valid |-> $past(!hit_ready)); // R9
    AST_DELAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_eff >= DLY_W'(DLY_MIN)) && (delay_eff <= DLY_W'(DLY_MAX))); // R5

endmodule

// File: tb/delay_buffer_writer_test.sv
module delay_buffer_writer_test;

    localparam int TS_W = 10, CNT_W = 6, IDX_W = 5, DLY_W = 5;
    localparam int PAYLOAD_W = 16, CNTR_W = 4;
    localparam int ADDR_W = TS_W + CNT_W;
    localparam int CMAX = (1 << CNTR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TS_W-1:0] cur_ts = '0;
    logic [DLY_W-1:0] delay_cfg = 5'd20;
    logic hit_valid = 1'b0;
    logic hit_ready;
    logic [TS_W-1:0] hit_ts = '0;
    logic [PAYLOAD_W-1:0] hit_data = '0;
    logic sram_we, sram_end, age_valid;
    logic [ADDR_W-1:0] sram_addr;
    logic [PAYLOAD_W-1:0] sram_wdata;
    logic [TS_W-1:0] age_ts;
    logic [CNT_W:0] age_count;
    logic [CNTR_W-1:0] rej_cnt, ovf_cnt;

    always #4 clk = ~clk;

    delay_buffer_writer #(
        .TS_W(TS_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .DLY_W(DLY_W),
        .PAYLOAD_W(PAYLOAD_W), .CNTR_W(CNTR_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cur_ts(cur_ts), .delay_cfg(delay_cfg),
        .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_ts(hit_ts),
        .hit_data(hit_data), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_end(sram_end), .sram_wdata(sram_wdata), .age_valid(age_valid),
        .age_ts(age_ts), .age_count(age_count), .rej_cnt(rej_cnt), .ovf_cnt(ovf_cnt)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model, built from the requirements
    int mcnt [32];
    int mcur = 0;
    int mrej = 0;
    int movf = 0;
    logic [ADDR_W+PAYLOAD_W:0] exp_q [$];
    string tag_q [$];
    bit exp_age = 1'b0;
    int exp_ats = 0;
    int exp_acnt = 0;
    string age_tag = "R7";

    task automatic chk(string req, string what, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_delay();
        int d = int'(delay_cfg);
        if (d < 1) d = 1;
        if (d > 30) d = 30;
        return d;
    endfunction

    // monitor: scoreboard of SRAM writes and closing strobes
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_we) begin
                if (exp_q.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R2 unexpected write: actual addr %0h end %0d expected none",
                             sram_addr, sram_end);
                end else begin
                    logic [ADDR_W+PAYLOAD_W:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, "write word", longint'({sram_end, sram_addr, sram_wdata}), longint'(e));
                end
            end
            if (age_valid || exp_age) begin
                chk(age_tag, "age_valid", longint'(age_valid), longint'(exp_age));
                if (exp_age) begin
                    chk(age_tag, "age_ts", longint'(age_ts), longint'(exp_ats));
                    chk(age_tag, "age_count", longint'(age_count), longint'(exp_acnt));
                end
                exp_age = 1'b0;
            end
        end
    end

    task automatic send_hit(int ts, int data, string tag);
        int age, idx;
        @(negedge clk);
        hit_valid = 1'b1;
        hit_ts    = TS_W'(ts);
        hit_data  = PAYLOAD_W'(data);
        @(posedge clk);
        #1;
        hit_valid = 1'b0;
        age = (mcur - ts) & 1023;
        idx = ts & 31;
        if (age > eff_delay()) begin
            if (mrej < CMAX) mrej++;
        end else if (mcnt[idx] == 64) begin
            if (movf < CMAX) movf++;
        end else begin
            exp_q.push_back({1'b0, TS_W'(ts), CNT_W'(mcnt[idx]), PAYLOAD_W'(data)});
            tag_q.push_back(tag);
            mcnt[idx]++;
        end
        @(negedge clk);
        #1;
        chk(tag, "rej_cnt", longint'(rej_cnt), longint'(mrej));
        chk(tag, "ovf_cnt", longint'(ovf_cnt), longint'(movf));
    endtask

    task automatic advance(int nc, bit with_hit, int hts, string tag);
        int t, idx;
        @(negedge clk);
        cur_ts = TS_W'(nc);
        mcur = nc;
        if (with_hit) begin
            hit_valid = 1'b1;
            hit_ts    = TS_W'(hts);
            hit_data  = 16'hBEEF;
        end
        #1;
        if (with_hit) chk("R9", "hit_ready on step", longint'(hit_ready), 0);
        @(posedge clk);
        #1;
        hit_valid = 1'b0;
        t = (nc - eff_delay() - 1) & 1023;
        idx = t & 31;
        age_tag = tag;
        exp_ats = t;
        exp_acnt = mcnt[idx];
        exp_age = 1'b1;
        if (mcnt[idx] != 64) begin
            exp_q.push_back({1'b1, TS_W'(t), CNT_W'(mcnt[idx]), PAYLOAD_W'(0)});
            tag_q.push_back(tag);
        end
        mcnt[idx] = 0;
        @(negedge clk);
        #1;
        if (with_hit) begin
            chk("R9", "rej_cnt after stalled hit", longint'(rej_cnt), longint'(mrej));
            chk("R9", "ovf_cnt after stalled hit", longint'(ovf_cnt), longint'(movf));
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mcnt[i] = 0;
        repeat (3) @(negedge clk);
        chk("R1", "sram_we in reset", longint'(sram_we), 0);
        chk("R1", "age_valid in reset", longint'(age_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "sram_we", longint'(sram_we), 0);
        chk("R1", "sram_end", longint'(sram_end), 0);
        chk("R1", "rej_cnt", longint'(rej_cnt), 0);
        chk("R1", "ovf_cnt", longint'(ovf_cnt), 0);
        chk("R1", "hit_ready", longint'(hit_ready), 1);

        advance(100, 1'b0, 0, "R8");           // closes 79 with zero hits
        for (int i = 0; i < 3; i++) send_hit(100, 16'h1000 + i, "R3");
        send_hit(95, 16'h2222, "R2");
        send_hit(80, 16'h3333, "R4");          // age equals delay
        send_hit(79, 16'h4444, "R4");          // one too old
        send_hit(101, 16'h5555, "R4");         // stamp ahead of counter

        delay_cfg = 5'd0;
        send_hit(99, 16'h6666, "R5");
        send_hit(98, 16'h7777, "R5");
        delay_cfg = 5'd31;
        send_hit(70, 16'h8888, "R5");
        send_hit(69, 16'h9999, "R5");
        advance(101, 1'b0, 0, "R5");           // closes 70 with limit 30
        delay_cfg = 5'd20;

        for (int c = 102; c <= 121; c++) advance(c, 1'b0, 0, "R7");
        advance(122, 1'b1, 122, "R9");

        for (int i = 0; i < 66; i++) send_hit(122, 16'hA000 + i, "R6");
        for (int c = 123; c <= 143; c++) advance(c, 1'b0, 0, "R8");

        for (int i = 0; i < 16; i++) send_hit(0, 16'hC000 + i, "R10");

        advance(1020, 1'b0, 0, "R7");
        send_hit(1010, 16'hD001, "R4");
        for (int c = 1021; c <= 1026; c++) advance(c & 1023, 1'b0, 0, "R7");
        send_hit(1015, 16'hD002, "R4");        // age 11 across the wrap
        send_hit(1000, 16'hD003, "R4");        // age 26 across the wrap

        repeat (3) @(negedge clk);
        chk("R2", "pending expected writes", longint'(exp_q.size()), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule